// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block sequences single conversions of a successive-approximation analog-to-digital converter. Software reaches it through a small word-addressed register bus. It holds the channel choice, the power and interrupt settings, a power-up delay and the last result. The analog parts sit outside the block: a DAC driven by the block's trial code, and a comparator that reports whether the sampled input is at or above that trial level.

A control write with the power bit set, made while the block is idle, does four things in order. It powers the converter and drives the chosen channel. It then waits the programmed number of clock periods and resolves the result one bit per cycle, starting from the most significant bit. Finally it stores the code and, if interrupts are enabled, flags an interrupt. Software normally clears the interrupt and powers the converter down by writing zero to the control word. The same zero write also cancels a conversion that is still running.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset every register reads zero, and pwr_en, irq, dac_code and chan_sel are all low.
- R2: Register map by byte address (bus_addr[3:2] selects the word). 0x0 is the result, right-aligned, with its upper bits reading zero. 0x4 is status, with bit 0 = busy. 0x8 is control: bits 2:0 channel, bit 3 power, bit 5 interrupt enable, bit 6 interrupt pending (read-only). 0xC is the delay, 6 bits wide, with its upper bits reading zero.
- R3: A control write with bit 3 set while idle raises pwr_en, drives the written channel on chan_sel and sets busy, all from the next cycle.
- R4: While powered and waiting, dac_code stays zero for DLY+1 cycles after the start write, where DLY is the delay register value. The first trial code is then the MSB alone.
- R5: The search tests one bit per cycle, MSB first. It keeps a bit when cmp_hi is high. The stored result is the largest code whose level does not exceed the input. Busy lasts exactly DLY+1+RES_BITS cycles.
- R6: The result register keeps its value until the next conversion completes, including across an aborted conversion.
- R7: On completion, irq and the pending bit rise only when interrupt enable is set. irq is never high while enable is clear.
- R8: Any control write clears a pending interrupt, unless a conversion completes in that same cycle.
- R9: A control write with bit 3 clear (zero included) aborts any conversion. From the next cycle pwr_en, busy, irq and dac_code are all low.
- R10: While busy, a control write with bit 3 set neither changes the channel nor restarts the sequence, and chan_sel and pwr_en hold steady.
- R11: dac_code is zero whenever no conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cmp_hi | input | 1 | Comparator: input at or above the trial level |
| dac_code | output | RES_BITS | Trial code for the DAC |
| chan_sel | output | CH_BITS | Analog channel select |
| pwr_en | output | 1 | Converter power enable |
| irq | output | 1 | Conversion-done interrupt |

## Verification
Some rules are checked on every cycle. The channel holds while busy, busy implies power, irq requires interrupt enable, a zero control write lands the block in an idle, unpowered, quiet state, and dac_code is zero when idle. Other behaviour shows only in the bench's scenarios. This covers the exact delay and busy lengths, the resolved code for inputs at the scale ends and around mid-scale, the retention of the result across an abort, and the clearing of a pending interrupt by a later control write.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    // Word index taken from bus_addr[3:2]
    localparam logic [1:0] IDX_RESULT = 2'd0;
    localparam logic [1:0] IDX_STATUS = 2'd1;
    localparam logic [1:0] IDX_CTRL   = 2'd2;
    localparam logic [1:0] IDX_DELAY  = 2'd3;

    // Control word bit positions
    localparam int CB_PWR = 3;
    localparam int CB_IE  = 5;
    localparam int CB_IRQ = 6;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_CONV = 2'd2
    } seq_state_e;

    // Decoded command from the register bank to the sequencer
    typedef struct packed {
        logic launch;
        logic kill;
    } seq_cmd_t;

    function automatic logic [1:0] word_index(input logic [ADDR_W-1:0] a);
        return a[3:2];
    endfunction
endpackage

// File: rtl/sar_search.sv
`timescale 1ns/1ps
module sar_search #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] trial,
    output logic                finish,
    output logic [RES_BITS-1:0] final_code
);
    localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] trial_q;
    logic [RES_BITS-1:0] probe_q;
    logic                active_q;
    logic [RES_BITS-1:0] resolved;

    // Keep the bit under test only when the input is at or above the trial level
    assign resolved   = cmp_hi ? trial_q : (trial_q & ~probe_q);
    assign finish     = active_q && probe_q[0];
    assign final_code = resolved;
    assign trial      = trial_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            trial_q  <= '0;
            probe_q  <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            trial_q  <= MSB_MASK;
            probe_q  <= MSB_MASK;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (probe_q[0]) begin
                trial_q  <= '0;
                probe_q  <= '0;
                active_q <= 1'b0;
            end else begin
                trial_q <= resolved | (probe_q >> 1);
                probe_q <= probe_q >> 1;
            end
        end
    end
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
    import sar_pkg::*;
#(
    parameter int DLY_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  seq_cmd_t            cmd,
    input  logic [DLY_BITS-1:0] dly_val,
    input  logic                finish,
    output logic                busy,
    output logic                srch_start
);
    seq_state_e          state_q;
    logic [DLY_BITS-1:0] cnt_q;

    assign busy       = (state_q != SQ_IDLE);
    assign srch_start = (state_q == SQ_WAIT) && (cnt_q == '0) && !cmd.kill;

    always_ff @(posedge clk) begin
        if (rst || cmd.kill) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (cmd.launch) begin
                        state_q <= SQ_WAIT;
                        cnt_q   <= dly_val;
                    end
                end
                SQ_WAIT: begin
                    if (cnt_q == '0) state_q <= SQ_CONV;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                SQ_CONV: begin
                    if (finish) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_regs.sv
`timescale 1ns/1ps
module sar_regs
    import sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CH_BITS  = 3,
    parameter int DLY_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                busy,
    input  logic                finish,
    input  logic [RES_BITS-1:0] final_code,
    output seq_cmd_t            cmd,
    output logic [DLY_BITS-1:0] dly_val,
    output logic [CH_BITS-1:0]  chan,
    output logic                pwr,
    output logic                ie,
    output logic                irq
);
    logic [RES_BITS-1:0] result_q;
    logic [DLY_BITS-1:0] dly_q;
    logic [CH_BITS-1:0]  ch_q;
    logic                pwr_q, ie_q, irq_q;
    logic                ctrl_wr, dly_wr, ie_eff, capture;
    logic [1:0]          widx;

    assign widx    = word_index(bus_addr);
    assign ctrl_wr = bus_wr && (widx == IDX_CTRL);
    assign dly_wr  = bus_wr && (widx == IDX_DELAY);

    assign cmd.kill   = ctrl_wr && !bus_wdata[CB_PWR];
    assign cmd.launch = ctrl_wr &&  bus_wdata[CB_PWR] && !busy;

    assign ie_eff  = ctrl_wr ? bus_wdata[CB_IE] : ie_q;
    assign capture = finish && !cmd.kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            dly_q    <= '0;
            ch_q     <= '0;
            pwr_q    <= 1'b0;
            ie_q     <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (dly_wr) dly_q <= bus_wdata[DLY_BITS-1:0];
            if (ctrl_wr) begin
                ie_q  <= bus_wdata[CB_IE];
                pwr_q <= bus_wdata[CB_PWR];
                if (!busy) ch_q <= bus_wdata[CH_BITS-1:0];
            end
            if (capture) result_q <= final_code;
            if (capture && ie_eff) irq_q <= 1'b1;
            else if (ctrl_wr)      irq_q <= 1'b0;
        end
    end

    // Zero-extended views of the narrow registers
    logic [BUS_W-1:0] result_word, dly_word, ctrl_word;
    generate
        if (RES_BITS < BUS_W) begin : g_res_pad
            assign result_word = {{(BUS_W-RES_BITS){1'b0}}, result_q};
        end else begin : g_res_full
            assign result_word = result_q[BUS_W-1:0];
        end
    endgenerate
    assign dly_word = {{(BUS_W-DLY_BITS){1'b0}}, dly_q};

    always_comb begin
        ctrl_word                 = '0;
        ctrl_word[CH_BITS-1:0]    = ch_q;
        ctrl_word[CB_PWR]         = pwr_q;
        ctrl_word[CB_IE]          = ie_q;
        ctrl_word[CB_IRQ]         = irq_q;
    end

    always_comb begin
        case (widx)
            IDX_RESULT: bus_rdata = result_word;
            IDX_STATUS: bus_rdata = {{(BUS_W-1){1'b0}}, busy};
            IDX_CTRL:   bus_rdata = ctrl_word;
            default:    bus_rdata = dly_word;
        endcase
    end

    assign dly_val = dly_q;
    assign chan    = ch_q;
    assign pwr     = pwr_q;
    assign ie      = ie_q;
    assign irq     = irq_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CH_BITS  = 3,
    parameter int DLY_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CH_BITS-1:0]  chan_sel,
    output logic                pwr_en,
    output logic                irq
);
    seq_cmd_t            cmd_w;
    logic [DLY_BITS-1:0] dly_w;
    logic                seq_busy, srch_start, srch_finish, ie_w;
    logic [RES_BITS-1:0] final_w;

    sar_regs #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS), .DLY_BITS(DLY_BITS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (seq_busy),
        .finish     (srch_finish),
        .final_code (final_w),
        .cmd        (cmd_w),
        .dly_val    (dly_w),
        .chan       (chan_sel),
        .pwr        (pwr_en),
        .ie         (ie_w),
        .irq        (irq)
    );

    sar_seq #(.DLY_BITS(DLY_BITS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd_w),
        .dly_val    (dly_w),
        .finish     (srch_finish),
        .busy       (seq_busy),
        .srch_start (srch_start)
    );

    sar_search #(.RES_BITS(RES_BITS)) u_search (
        .clk        (clk),
        .rst        (rst),
        .start      (srch_start),
        .abort      (cmd_w.kill),
        .cmp_hi     (cmp_hi),
        .trial      (dac_code),
        .finish     (srch_finish),
        .final_code (final_w)
    );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
module sar_conv_ctrl_chk #(
    parameter int RES_BITS = 10,
    parameter int CH_BITS  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [3:0]          bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic [RES_BITS-1:0] dac_code,
    input logic [CH_BITS-1:0]  chan_sel,
    input logic                pwr_en,
    input logic                irq,
    input logic                busy,
    input logic                ie
);
    a_r10_chan_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(chan_sel)));

    a_r10_power_hold: assert property (@(posedge clk) disable iff (rst)
        busy |-> pwr_en);

    a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);

    a_r9_zero_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[3:2] == 2'd2 && bus_wdata == 32'd0)
        |=> (!pwr_en && !irq && !busy && dac_code == '0));

    a_r11_dac_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .dac_code  (dac_code),
    .chan_sel  (chan_sel),
    .pwr_en    (pwr_en),
    .irq       (irq),
    .busy      (seq_busy),
    .ie        (ie_w)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
    localparam int N = 10;
    localparam logic [3:0] A_RES = 4'h0, A_STAT = 4'h4, A_CTRL = 4'h8, A_DLY = 4'hC;
    // {ie, channel[2:0], delay[5:0], input level[9:0]}
    localparam logic [19:0] VEC [0:7] = '{
        {1'b1, 3'd0, 6'd8,  10'd0},
        {1'b1, 3'd5, 6'd0,  10'd1023},
        {1'b0, 3'd2, 6'd63, 10'd512},
        {1'b1, 3'd7, 6'd1,  10'd511},
        {1'b1, 3'd3, 6'd8,  10'd341},
        {1'b0, 3'd6, 6'd3,  10'd682},
        {1'b1, 3'd1, 6'd8,  10'd1},
        {1'b1, 3'd4, 6'd5,  10'd777}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, bus_wr, cmp_hi, pwr_en, irq;
    logic [3:0]    bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [N-1:0]  dac_code, vin;
    logic [2:0]    chan_sel;

    assign cmp_hi = (vin >= dac_code);

    sar_conv_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .chan_sel(chan_sel), .pwr_en(pwr_en), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Called at the negedge right after a start write
    task automatic run_conv(output int busy_cyc, output int wait_cyc, output logic [N-1:0] first);
        logic [31:0] s;
        bit seen;
        busy_cyc = 0; wait_cyc = 0; first = '0; seen = 1'b0;
        forever begin
            rd(A_STAT, s);
            if (!s[0] || busy_cyc > 2000) break;
            busy_cyc++;
            if (!seen) begin
                if (dac_code == '0) wait_cyc++;
                else begin seen = 1'b1; first = dac_code; end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [19:0] v;
        logic        ie;
        logic [2:0]  ch;
        logic [5:0]  dly;
        int          bc, wc;
        logic [N-1:0] fc;

        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; vin = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(A_RES, r);  check("R1 result", r, 0);
        rd(A_STAT, r); check("R1 status", r, 0);
        rd(A_CTRL, r); check("R1 control", r, 0);
        rd(A_DLY, r);  check("R1 delay", r, 0);
        check("R1 outputs", {pwr_en, irq, chan_sel, 22'(dac_code)}, 0);

        // Vector table: one full conversion per entry
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            ie = v[19]; ch = v[18:16]; dly = v[15:10]; vin = v[9:0];
            wr(A_DLY, 32'(dly));
            wr(A_CTRL, 32'(ie) << 5 | 32'h8 | 32'(ch));
            check("R3 pwr_en", 32'(pwr_en), 1);
            check("R3 chan_sel", 32'(chan_sel), 32'(ch));
            run_conv(bc, wc, fc);
            check("R5 busy length", bc, dly + 1 + N);
            check("R4 wait length", wc, dly + 1);
            check("R4 first trial", 32'(fc), 32'h200);
            rd(A_RES, r);  check("R5 R6 result", r, 32'(vin));
            check("R7 irq", 32'(irq), 32'(ie));
            rd(A_CTRL, r); check("R2 control fields", r, 32'(ie) << 6 | 32'(ie) << 5 | 32'h8 | 32'(ch));
            check("R11 dac idle", 32'(dac_code), 0);
            wr(A_CTRL, 0);
            check("R9 power down", {pwr_en, irq}, 0);
        end

        // R2 register widths and field positions
        wr(A_DLY, 32'hFFFF_FFFF);
        rd(A_DLY, r);  check("R2 delay width", r, 32'h3F);
        wr(A_CTRL, 32'h27);
        rd(A_CTRL, r); check("R2 control no power", r, 32'h27);
        check("R2 not started", 32'(pwr_en), 0);
        rd(A_STAT, r); check("R2 status idle", r, 0);

        // R10 channel write during busy is ignored, no restart
        wr(A_DLY, 20); vin = 10'd300;
        wr(A_CTRL, 32'h8 | 32'd2);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'h28 | 32'd5);
        check("R10 chan hold", 32'(chan_sel), 2);
        rd(A_CTRL, r); check("R10 chan field", r & 32'h7, 2);
        rd(A_STAT, r); check("R10 still busy", r, 1);
        run_conv(bc, wc, fc);
        check("R10 no restart", bc, 21 + N - 7);
        rd(A_RES, r);  check("R10 result", r, 300);
        check("R7 irq after late enable", 32'(irq), 1);

        // R8 control write clears pending interrupt
        wr(A_CTRL, 32'h20);
        check("R8 irq cleared", 32'(irq), 0);
        rd(A_CTRL, r); check("R8 pending bit", r[6], 0);

        // R9 abort by zero write, R6 result kept
        wr(A_DLY, 8); vin = 10'd900;
        wr(A_CTRL, 32'h28 | 32'd1);
        repeat (12) @(negedge clk);
        check("R9 converting before abort", 32'(dac_code != 0), 1);
        wr(A_CTRL, 0);
        check("R9 abort outputs", {pwr_en, irq, 22'(dac_code)}, 0);
        rd(A_STAT, r); check("R9 abort busy", r, 0);
        repeat (30) @(negedge clk);
        rd(A_RES, r);  check("R6 kept after abort", r, 300);
        check("R9 no late irq", 32'(irq), 0);

        // R9 abort by nonzero write with power clear
        wr(A_CTRL, 32'h8 | 32'd3);
        repeat (4) @(negedge clk);
        wr(A_CTRL, 32'h20);
        check("R9 power-off abort", {pwr_en, 22'(dac_code)}, 0);
        rd(A_STAT, r); check("R9 power-off busy", r, 0);
        check("R11 dac idle after abort", 32'(dac_code), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule